// File: doc/BRIEF.md
# UART Modem Control and Status

This block holds the modem-control register of a 16550-style serial port and produces the modem-status byte that software reads back. The control register drives four handshake outputs: data-terminal-ready, request-to-send and two general-purpose outputs. The four handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) are synchronised and watched for changes. A change is latched as a delta flag, and any latched flag raises an interrupt request.

Setting the loopback bit in the control register disconnects the block from the line. All four external outputs are held low, and the status byte then reports the control bits in place of the external inputs. Data-terminal-ready feeds data-set-ready, request-to-send feeds clear-to-send, the first general output feeds ring indicator and the second general output feeds carrier detect. Firmware uses this to test the handshake and interrupt path without a cable. Reading the status byte through a one-cycle read strobe returns the levels and deltas and clears every delta.

Top module: `uart_modem_ctl`

## Requirements
- R1: The control register keeps write bits [4:0]: bit 0 terminal-ready, bit 1 request-to-send, bit 2 general output 1, bit 3 general output 2, bit 4 loopback. It reads back with bits [7:5] as 0, so writing 0xFF reads 0x1F.
- R2: With loopback clear, dtr_o, rts_o, out1_o and out2_o equal control bits 0, 1, 2 and 3 one cycle after the write.
- R3: With loopback set, dtr_o, rts_o, out1_o and out2_o are all 0 whatever the other control bits hold.
- R4: With loopback set, the status levels are taken from the control bits: bit 4 (CTS) is control bit 1, bit 5 (DSR) is control bit 0, bit 6 (RI) is control bit 2 and bit 7 (DCD) is control bit 3.
- R5: With loopback clear, status bits 4, 5, 6 and 7 show cts_i, dsr_i, ri_i and dcd_i after a two-flop synchroniser, two clock edges after the input changes.
- R6: Any change of the reported CTS, DSR or DCD level, rising or falling, sets status bit 0, 1 or 3 on the edge after the level appears, and irq_o is high while any of status bits [3:0] is set.
- R7: Status bit 2 (ring delta) is set only when the reported RI level goes from 1 to 0. A rise of RI leaves it clear and raises no interrupt.
- R8: A cycle with msr_re_i high clears status bits [3:0] and irq_o on the next edge, except that a change detected in that same cycle still sets its flag.
- R9: After reset the control register, all four outputs, all delta flags and irq_o are 0.
- R10: A delta flag stays set until a read, even if its line returns to the earlier level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcr_we_i | input | 1 | Control register write strobe |
| mcr_wdata_i | input | 8 | Control register write data |
| mcr_rdata_o | output | 8 | Control register readback |
| msr_re_i | input | 1 | Status read strobe; clears deltas |
| msr_rdata_o | output | 8 | Status byte: levels [7:4], deltas [3:0] |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| ri_i | input | 1 | Ring indicator line |
| dcd_i | input | 1 | Carrier detect line |
| dtr_o | output | 1 | Terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a line change that is detected in the same cycle as a status read. If the read won, that change would be lost silently. The stimulus raises carrier detect and waits the two synchroniser edges. It then asserts the read strobe exactly on the edge where the delta is latched, and expects both the flag and the interrupt to survive. Switching loopback on and off while the external inputs disagree with the control bits also exercises deltas that come from a change of source rather than from a line.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_LINES = 4;
  // control register bit positions
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_OUT1 = 2;
  localparam int unsigned C_OUT2 = 3;
  localparam int unsigned C_LOOP = 4;
  localparam int unsigned CTL_W  = C_LOOP + 1;
  // line index inside a level vector; status level bit = 4 + index
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_RI  = 2;
  localparam int unsigned L_DCD = 3;
  typedef logic [NUM_LINES-1:0] lvl_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             loop_o,
  output lvl_t             lb_lvl_o,
  output logic             dtr_o,
  output logic             rts_o,
  output logic             out1_o,
  output logic             out2_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i[CTL_W-1:0];
  end

  assign rdata_o = {{(REG_W-CTL_W){1'b0}}, ctl_q};
  assign loop_o  = ctl_q[C_LOOP];

  // outputs parked low while looped back
  assign dtr_o  = ctl_q[C_DTR]  & ~loop_o;
  assign rts_o  = ctl_q[C_RTS]  & ~loop_o;
  assign out1_o = ctl_q[C_OUT1] & ~loop_o;
  assign out2_o = ctl_q[C_OUT2] & ~loop_o;

  // internal routing matrix
  always_comb begin
    lb_lvl_o        = '0;
    lb_lvl_o[L_CTS] = ctl_q[C_RTS];
    lb_lvl_o[L_DSR] = ctl_q[C_DTR];
    lb_lvl_o[L_RI]  = ctl_q[C_OUT1];
    lb_lvl_o[L_DCD] = ctl_q[C_OUT2];
  end
endmodule

// File: rtl/modem_status.sv
module modem_status
  import modem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_i,
  input  lvl_t             lb_lvl_i,
  input  lvl_t             ext_lvl_i,
  input  logic             re_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  lvl_t lvl_cur, lvl_q, chg, set_vec, delta_q, delta_d;

  assign lvl_cur = loop_i ? lb_lvl_i : ext_lvl_i;
  assign chg     = lvl_cur ^ lvl_q;

  always_comb begin
    set_vec       = chg;
    set_vec[L_RI] = lvl_q[L_RI] & ~lvl_cur[L_RI];  // falling edge only
    delta_d       = (re_i ? '0 : delta_q) | set_vec;  // new change beats read
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_cur;
      delta_q <= delta_d;
    end
  end

  assign rdata_o = {lvl_cur, delta_q};
  assign irq_o   = |delta_q;

  AST_IRQ_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(lvl_cur) != $past(lvl_cur, 2))); // R6
  AST_RI_TRAILING_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[L_RI]) |-> (!$past(lvl_cur[L_RI]) && $past(lvl_cur[L_RI], 2))); // R7
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && lvl_cur == lvl_q) |=> (rdata_o[NUM_LINES-1:0] == '0 && !irq_o)); // R8
  AST_DELTA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!re_i && irq_o) |=> irq_o); // R10
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import modem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mcr_we_i,
  input  logic [7:0] mcr_wdata_i,
  output logic [7:0] mcr_rdata_o,
  input  logic       msr_re_i,
  output logic [7:0] msr_rdata_o,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       irq_o
);
  lvl_t ext_raw, ext_lvl, lb_lvl;
  logic loop;

  always_comb begin
    ext_raw        = '0;
    ext_raw[L_CTS] = cts_i;
    ext_raw[L_DSR] = dsr_i;
    ext_raw[L_RI]  = ri_i;
    ext_raw[L_DCD] = dcd_i;
  end

  modem_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_raw),
    .q_o   (ext_lvl)
  );

  modem_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mcr_we_i),
    .wdata_i (mcr_wdata_i),
    .rdata_o (mcr_rdata_o),
    .loop_o  (loop),
    .lb_lvl_o(lb_lvl),
    .dtr_o   (dtr_o),
    .rts_o   (rts_o),
    .out1_o  (out1_o),
    .out2_o  (out2_o)
  );

  modem_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .loop_i   (loop),
    .lb_lvl_i (lb_lvl),
    .ext_lvl_i(ext_lvl),
    .re_i     (msr_re_i),
    .rdata_o  (msr_rdata_o),
    .irq_o    (irq_o)
  );

  AST_LOOP_OUTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_rdata_o[C_LOOP] |-> !(dtr_o || rts_o || out1_o || out2_o)); // R3
  AST_LOOP_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_rdata_o[C_LOOP] |-> (msr_rdata_o[7:4] ==
      {mcr_rdata_o[C_OUT2], mcr_rdata_o[C_OUT1], mcr_rdata_o[C_DTR], mcr_rdata_o[C_RTS]})); // R4
  AST_MCR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_we_i |=> (mcr_rdata_o == {3'b000, $past(mcr_wdata_i[4:0])})); // R1
endmodule

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mcr_we = 1'b0;
  logic [7:0] mcr_wdata = '0;
  logic [7:0] mcr_rdata;
  logic       msr_re = 1'b0;
  logic [7:0] msr_rdata;
  logic       cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
  logic       dtr, rts, out1, out2, irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  uart_modem_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mcr_we_i(mcr_we), .mcr_wdata_i(mcr_wdata), .mcr_rdata_o(mcr_rdata),
    .msr_re_i(msr_re), .msr_rdata_o(msr_rdata),
    .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_mcr(input logic [7:0] d);
    mcr_we = 1'b1; mcr_wdata = d;
    tick(1);
    mcr_we = 1'b0;
  endtask

  // read status: check byte returned, then state after the clear
  task automatic rd_msr(input string req, input logic [7:0] exp);
    chk(req, msr_rdata, exp);
    msr_re = 1'b1;
    tick(1);
    msr_re = 1'b0;
    chk(req, {4'h0, msr_rdata[3:0]}, 8'h00);
    chk(req, {7'h0, irq}, 8'h00);
  endtask

  task automatic t_reset;
    chk("R9", mcr_rdata, 8'h00);
    chk("R9", {4'h0, dtr, rts, out1, out2}, 8'h00);
    chk("R9", msr_rdata, 8'h00);
    chk("R9", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_loopback;
    wr_mcr(8'hFF);
    chk("R1", mcr_rdata, 8'h1F);
    chk("R3", {4'h0, dtr, rts, out1, out2}, 8'h00);
    chk("R4", {msr_rdata[7:4], 4'h0}, 8'hF0);
    tick(1);
    chk("R7", msr_rdata, 8'hFB);  // RI rise gives no ring delta
    chk("R6", {7'h0, irq}, 8'h01);
    rd_msr("R8", 8'hFB);
    chk("R8", msr_rdata, 8'hF0);
    wr_mcr(8'h1B);  // OUT1 low: ring trailing edge
    chk("R4", {msr_rdata[7:4], 4'h0}, 8'hB0);
    tick(1);
    chk("R7", msr_rdata, 8'hB4);
    rd_msr("R8", 8'hB4);
    wr_mcr(8'h12);  // only RTS
    chk("R4", {msr_rdata[7:4], 4'h0}, 8'h10);
    chk("R3", {4'h0, dtr, rts, out1, out2}, 8'h00);
    tick(1);
    chk("R6", msr_rdata, 8'h1A);
    rd_msr("R8", 8'h1A);
    wr_mcr(8'h00);  // leave loopback, inputs all low
    tick(1);
    chk("R6", msr_rdata, 8'h01);
    rd_msr("R8", 8'h01);
  endtask

  task automatic t_outputs;
    wr_mcr(8'h05);
    chk("R2", {4'h0, dtr, rts, out1, out2}, 8'h0A);
    chk("R1", mcr_rdata, 8'h05);
    wr_mcr(8'hEA);
    chk("R2", {4'h0, dtr, rts, out1, out2}, 8'h05);
    chk("R1", mcr_rdata, 8'h0A);
    chk("R5", msr_rdata, 8'h00);  // outputs do not reach status
    wr_mcr(8'h00);
  endtask

  task automatic t_cts;
    cts = 1'b1;
    tick(1);
    chk("R5", msr_rdata, 8'h00);
    tick(1);
    chk("R5", msr_rdata, 8'h10);
    tick(1);
    chk("R6", msr_rdata, 8'h11);
    chk("R6", {7'h0, irq}, 8'h01);
    rd_msr("R8", 8'h11);
    cts = 1'b0;
    tick(3);
    chk("R6", msr_rdata, 8'h01);  // falling also flags
    rd_msr("R8", 8'h01);
  endtask

  task automatic t_ri;
    ri = 1'b1;
    tick(3);
    chk("R7", msr_rdata, 8'h40);
    chk("R7", {7'h0, irq}, 8'h00);
    ri = 1'b0;
    tick(3);
    chk("R7", msr_rdata, 8'h04);
    chk("R7", {7'h0, irq}, 8'h01);
    rd_msr("R8", 8'h04);
  endtask

  task automatic t_sticky;
    dsr = 1'b1;
    tick(4);
    dsr = 1'b0;
    tick(4);
    chk("R10", msr_rdata, 8'h02);
    chk("R10", {7'h0, irq}, 8'h01);
    rd_msr("R8", 8'h02);
  endtask

  task automatic t_read_race;
    dcd = 1'b1;
    tick(2);
    chk("R5", msr_rdata, 8'h80);
    msr_re = 1'b1;  // read on the edge the delta latches
    tick(1);
    msr_re = 1'b0;
    chk("R8", msr_rdata, 8'h88);
    chk("R8", {7'h0, irq}, 8'h01);
    rd_msr("R8", 8'h88);
    dcd = 1'b0;
    tick(3);
    rd_msr("R6", 8'h08);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_loopback();
    t_outputs();
    t_cts();
    t_ri();
    t_sticky();
    t_read_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule